// File: doc/BRIEF.md
# Stereo-Duplicating Serial Audio Transmitter

This block feeds the serial data input of an audio codec that expects a left slot followed by a right slot in every frame. The system supplies one 16-bit mono sample per frame, and the block sends that sample twice, back to back. The listener therefore hears the same signal on both channels. Bit timing comes from a one-cycle enable that marks each falling edge of the codec bit clock. The frame-sync pulse doubles as the load strobe. It is one bit period wide and recurs every 64 bit periods.

A word is captured on the falling-edge enable that falls inside the frame-sync pulse. Its most significant bit goes out at once, and every later falling-edge enable presents the next bit. After both copies, 32 bits in all, the line is held low until the next frame sync. The output moves only on falling-edge enables, so it is steady whenever the codec samples on the rising edge.

Top module: `stereo_dup_tx`

## Requirements
- R1: While `rstN` is low, `serOut` is 0 and any transmission in progress is abandoned.
- R2: A load happens only on a cycle where `loadStrobe` and `fallEn` are both high. On the clock edge ending that cycle, `serOut` takes bit 15 of `sampleIn`.
- R3: Bits leave most significant first. Each later `fallEn` cycle presents the next lower bit of the captured word, down to bit 0 on the 16th enable counted from the load.
- R4: Enables 17 to 32 after the load repeat the captured word, again from bit 15 down to bit 0, so both slots carry the same sample.
- R5: Once 32 bits have gone out, `serOut` is 0 on every further `fallEn` cycle until the next load.
- R6: `serOut` changes only on the clock edge ending a cycle in which `fallEn` is high. On every other edge it holds its value.
- R7: `loadStrobe` high without `fallEn` starts nothing, and `fallEn` pulses with no prior load leave `serOut` at 0.
- R8: A load during a transmission in progress restarts it with the new word, beginning again at bit 15.
- R9: Changes on `sampleIn` between loads do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStrobe | input | 1 | Frame-sync pulse used as load request |
| sampleIn | input | 16 | Parallel mono sample |
| fallEn | input | 1 | One-cycle marker of a bit-clock falling edge |
| serOut | output | 1 | Serial data toward the codec |

## Verification
The bound checker keeps its own count of enables since the last load and its own copy of the captured word. With these it checks on every cycle that the output is stable between enables, that a load puts out bit 15, that each later bit follows in order through both copies, and that the line is low once the 32 bits have gone out or before any load. Only the bench scenarios can show the rest. These are reset taking effect mid-stream, a strobe held for many cycles without an enable, a reload in the middle of a frame, and sample changes between loads. The bench also covers uneven gaps between enables and data patterns with all ones, all zeros, and isolated edge bits.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;
  // Strobes issued by the sequencer to the shift datapath.
  typedef struct packed {
    logic load;   // capture replicated word, present its top bit
    logic shift;  // present next stored bit
    logic flush;  // drive the line low
  } txCtrl_t;
endpackage

// File: rtl/sdtx_ctrl.sv
module sdtx_ctrl
  import sdtx_pkg::*;
#(
  parameter int IMG_W = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    loadStrobe,
  input  logic    fallEn,
  output txCtrl_t ctrl
);
  localparam int CNT_W = $clog2(IMG_W + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(IMG_W - 1);

  // Bits still waiting in the image after the one on the line.
  logic [CNT_W-1:0] remaining;
  logic             pending;

  assign pending    = (remaining != '0);
  assign ctrl.load  = fallEn & loadStrobe;
  assign ctrl.shift = fallEn & ~loadStrobe & pending;
  assign ctrl.flush = fallEn & ~loadStrobe & ~pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remaining <= '0;
    end else if (ctrl.load) begin
      remaining <= RELOAD;
    end else if (ctrl.shift) begin
      remaining <= remaining - 1'b1;
    end
  end
endmodule

// File: rtl/sdtx_dpath.sv
module sdtx_dpath
  import sdtx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COPIES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  txCtrl_t             ctrl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                serOut
);
  localparam int IMG_W = SAMPLE_W * COPIES;

  logic [IMG_W-1:0] wideWord;
  logic [IMG_W-1:0] image;
  logic             lineBit;

  // One slot per channel, all carrying the same sample.
  for (genvar g = 0; g < COPIES; g++) begin : g_slot
    assign wideWord[g*SAMPLE_W +: SAMPLE_W] = sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      image   <= '0;
      lineBit <= 1'b0;
    end else if (ctrl.load) begin
      image   <= {wideWord[IMG_W-2:0], 1'b0};
      lineBit <= wideWord[IMG_W-1];
    end else if (ctrl.shift) begin
      image   <= {image[IMG_W-2:0], 1'b0};
      lineBit <= image[IMG_W-1];
    end else if (ctrl.flush) begin
      lineBit <= 1'b0;
    end
  end

  assign serOut = lineBit;
endmodule

// File: rtl/stereo_dup_tx.sv
module stereo_dup_tx
  import sdtx_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COPIES   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadStrobe,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                fallEn,
  output logic                serOut
);
  localparam int IMG_W = SAMPLE_W * COPIES;

  txCtrl_t ctrl;

  sdtx_ctrl #(.IMG_W(IMG_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .fallEn     (fallEn),
    .ctrl       (ctrl)
  );

  sdtx_dpath #(.SAMPLE_W(SAMPLE_W), .COPIES(COPIES)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .sampleIn (sampleIn),
    .serOut   (serOut)
  );
endmodule

// File: rtl/sdtx_check.sv
module sdtx_check #(
  parameter int SAMPLE_W = 16,
  parameter int COPIES   = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                loadStrobe,
  input logic [SAMPLE_W-1:0] sampleIn,
  input logic                fallEn,
  input logic                serOut
);
  localparam int IMG_W = SAMPLE_W * COPIES;
  localparam int IDLE  = IMG_W + 1;
  localparam int CW    = $clog2(IMG_W + 2);

  logic [CW-1:0]       sentCnt;
  logic [SAMPLE_W-1:0] capWord;
  logic                expBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sentCnt <= CW'(IDLE);
      capWord <= '0;
    end else if (fallEn) begin
      if (loadStrobe) begin
        capWord <= sampleIn;
        sentCnt <= CW'(1);
      end else if (int'(sentCnt) < IDLE) begin
        sentCnt <= sentCnt + 1'b1;
      end
    end
  end

  always_comb begin
    int pos;
    pos    = (int'(sentCnt) - 1) % SAMPLE_W;
    expBit = capWord[SAMPLE_W-1-pos];
  end

  assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(fallEn && loadStrobe) |-> serOut == $past(sampleIn[SAMPLE_W-1]));

  assert_bit_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sentCnt >= CW'(1) && sentCnt <= CW'(SAMPLE_W)) |-> serOut == expBit);

  assert_second_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sentCnt > CW'(SAMPLE_W) && sentCnt <= CW'(IMG_W)) |-> serOut == expBit);

  // R7: before any load the counter sits at IDLE, so this also covers idle enables.
  assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    sentCnt == CW'(IDLE) |-> !serOut);

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(fallEn) |-> $stable(serOut));
endmodule

bind stereo_dup_tx sdtx_check #(.SAMPLE_W(SAMPLE_W), .COPIES(COPIES)) i_sdtx_check (
  .clk        (clk),
  .rstN       (rstN),
  .loadStrobe (loadStrobe),
  .sampleIn   (sampleIn),
  .fallEn     (fallEn),
  .serOut     (serOut)
);

// File: tb/test_stereo_dup_tx.sv
`timescale 1ns/1ps
module test_stereo_dup_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [15:0] sampleIn = '0;
  logic        fallEn = 1'b0;
  logic        serOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic  expQ[$];
  string tagQ[$];

  // Bench reference model state
  logic [15:0] mCap = '0;
  int          mCnt = 33;

  logic seenFall = 1'b0;
  logic lastOut  = 1'b0;
  bit   monOn    = 0;

  always #2.5 clk = ~clk;

  stereo_dup_tx i_stereo_dup_tx (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe),
    .sampleIn(sampleIn), .fallEn(fallEn), .serOut(serOut)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: serOut=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) seenFall <= fallEn;

  // Monitor: pops one expected bit per enable, checks holding otherwise.
  always @(negedge clk) begin
    if (monOn) begin
      if (seenFall) begin
        if (expQ.size() == 0) begin
          check(serOut, 1'bx, "R6 unexpected enable");
        end else begin
          logic e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(serOut, e, t);
        end
      end else begin
        check(serOut, lastOut, "R6");
      end
    end
    lastOut = serOut;
  end

  task automatic step(input logic strobe, input logic [15:0] word,
                      input int gap, input string tag);
    logic e;
    @(negedge clk);
    loadStrobe = strobe;
    sampleIn   = word;
    fallEn     = 1'b1;
    if (strobe) begin
      mCap = word; e = word[15]; mCnt = 1;
    end else if (mCnt >= 1 && mCnt < 32) begin
      e = mCap[15 - (mCnt % 16)]; mCnt++;
    end else begin
      e = 1'b0; mCnt = 33;
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    fallEn = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // One 64-slot frame; if scramble, sampleIn is inverted after the load (R9).
  task automatic frame(input logic [15:0] word, input int gap, input bit scramble);
    step(1'b1, word, gap, "R2");
    loadStrobe = 1'b0;
    for (int i = 1; i < 64; i++) begin
      logic [15:0] w;
      w = scramble ? ~word ^ 16'(i) : word;
      if (i < 16)      step(1'b0, w, gap, scramble ? "R9" : "R3");
      else if (i < 32) step(1'b0, w, gap, scramble ? "R9" : "R4");
      else             step(1'b0, w, gap, "R5");
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(serOut, 1'b0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
    lastOut = serOut;
    monOn = 1;

    // R7: idle enables and a long strobe without enable
    for (int i = 0; i < 4; i++) step(1'b0, 16'hFFFF, 1, "R7 idle");
    @(negedge clk); loadStrobe = 1'b1; sampleIn = 16'hFFFF;
    repeat (6) @(negedge clk);
    loadStrobe = 1'b0;
    for (int i = 0; i < 3; i++) step(1'b0, 16'hFFFF, 2, "R7 strobe only");

    frame(16'hA5C3, 1, 0);
    frame(16'hFFFF, 3, 0);
    frame(16'h8001, 0, 0);
    frame(16'h0000, 2, 0);
    frame(16'h6D29, 1, 1);

    // R8: reload mid-stream
    step(1'b1, 16'h1234, 1, "R2");
    for (int i = 1; i < 10; i++) step(1'b0, 16'h0, 1, "R3");
    step(1'b1, 16'hC0DE, 1, "R8");
    for (int i = 1; i < 40; i++) step(1'b0, 16'h0, 1, "R8");

    // R1: reset mid-stream
    step(1'b1, 16'hFFFF, 1, "R2");
    for (int i = 1; i < 5; i++) step(1'b0, 16'h0, 1, "R3");
    monOn = 0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(serOut, 1'b0, "R1 mid-stream");
    @(negedge clk); rstN = 1'b1;
    mCnt = 33;
    lastOut = serOut;
    monOn = 1;
    for (int i = 0; i < 4; i++) step(1'b0, 16'hFFFF, 1, "R1 after reset");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      compared++; mismatched++;
      $display("FAIL R6: %0d results missing, expected=0", expQ.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule